// File: doc/BRIEF.md
# Unit-Step Counter Machine Sequencer

This block is a tiny program-driven sequencer with no arithmetic unit. Its only data operations are "add one" and "subtract one" on a single register. Its only control transfer is a branch taken when a register reads zero. The program words sit in their own store, apart from the data registers, and every instruction names its register directly.

Software-side logic loads the program through a write port, or the program comes from a parameter image at reset. The same logic seeds the data registers through a preload port and pulses `start_i`. The sequencer then executes one instruction per clock until it meets a stop word or runs past the last program slot. It then raises `halted_o`, and the results are read back through a combinational read port.

Data registers are fixed width. They saturate at zero and at their maximum value, and each case is recorded in a sticky flag. A parameter selects a second flavour of the machine, in which every increment names its successor address and the decrement opcode becomes a combined zero-test-and-decrement with two target addresses.

Top module: `cm_sequencer`

## Requirements
- R1: An instruction word is {op[1:0], reg, za, zb}, with op in the top two bits, the register index next, then the address field za and the address field zb in the low bits (12 bits at default parameters: op [11:10], reg [9:8], za [7:4], zb [3:0]). The op codes are 00 increment, 01 decrement, 10 branch-on-zero and 11 stop. In sequential mode an increment adds one to the named register and moves the program counter to the next address.
- R2: In sequential mode a decrement of a non-zero register subtracts one from it and moves the program counter to the next address.
- R3: Branch-on-zero loads the program counter with za when the named register reads zero, and otherwise moves to the next address. Branching on a register that is never written gives an unconditional jump.
- R4: A stop word raises `halted_o`. From then on the program counter stays on the stop address and no register changes until the next start.
- R5: Reaching an address at or beyond the program depth behaves as a stop, and `pc_o` shows that address.
- R6: A decrement of a register that holds zero leaves it at zero and sets `unf_o`, which stays set for the rest of the run.
- R7: An increment of a register that holds all ones leaves it unchanged and sets `ovf_o`, which stays set for the rest of the run.
- R8: `start_i` while the machine is not running clears both flags and `halted_o` and runs from address 0. One instruction executes per following clock. `start_i` during a run is ignored.
- R9: Register preloads and program writes take effect only while the machine is not running. A preload in the same cycle as `start_i` is seen by the first instruction.
- R10: With NEXT_ADDR_MODE=1 an increment jumps to za. Op 01 becomes a combined test: it jumps to za if the register is zero, and otherwise decrements it and jumps to zb, never setting `unf_o`.
- R11: After reset the machine is idle, with `pc_o` 0, `halted_o`, `ovf_o` and `unf_o` low, and all registers zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run from address 0 |
| prog_we_i | input | 1 | Program word write enable |
| prog_addr_i | input | AW | Program write address |
| prog_data_i | input | IW | Program word |
| pre_we_i | input | 1 | Register preload enable |
| pre_idx_i | input | RW | Preload register index |
| pre_val_i | input | REG_W | Preload value |
| rd_idx_i | input | RW | Read port register index |
| rd_val_o | output | REG_W | Read port value (combinational) |
| pc_o | output | AW+1 | Program counter |
| halted_o | output | 1 | Run finished |
| ovf_o | output | 1 | Sticky increment-at-maximum flag |
| unf_o | output | 1 | Sticky decrement-at-zero flag |

## Verification
The two functions that can share a cycle are the load ports and instruction execution. A preload can land in the start cycle, and a new `start_i`, a preload or a program write can arrive while an instruction is retiring. The bench drives a preload together with `start_i` and expects the first instruction to use the new value. It also fires `start_i`, a preload and a program write on the first execution cycle of a copy loop, and expects unchanged results, an unchanged stop address and the exact number of clocks from start to halt.

// File: rtl/cms_pkg.sv
package cms_pkg;
  localparam int OP_W = 2;

  typedef enum logic [1:0] {
    OP_INC  = 2'b00,
    OP_DEC  = 2'b01,
    OP_JZ   = 2'b10,
    OP_HALT = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_DONE = 2'b10
  } st_e;
endpackage

// File: rtl/cms_prog_store.sv
module cms_prog_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int IW    = 12,
  parameter logic [DEPTH*IW-1:0] INIT_IMAGE = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [IW-1:0] wdata_i,
  input  logic [AW:0]   fetch_addr_i,
  output logic [IW-1:0] word_o,
  output logic          in_range_o
);
  logic [IW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT_IMAGE[i*IW +: IW];
    end else if (we_i && (32'(waddr_i) < DEPTH)) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // Out-of-range fetch yields a stop word (all ones)
  assign in_range_o = (32'(fetch_addr_i) < DEPTH);
  assign word_o     = in_range_o ? mem_q[fetch_addr_i[AW-1:0]] : '1;
endmodule

// File: rtl/cms_regfile.sv
module cms_regfile #(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 8,
  parameter int RW       = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_we_i,
  input  logic [RW-1:0]    pre_idx_i,
  input  logic [REG_W-1:0] pre_val_i,
  input  logic             ex_we_i,
  input  logic [RW-1:0]    ex_idx_i,
  input  logic [REG_W-1:0] ex_val_i,
  output logic [REG_W-1:0] ex_rd_o,
  input  logic [RW-1:0]    rd_idx_i,
  output logic [REG_W-1:0] rd_val_o
);
  logic [REG_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_q[g] <= '0;
      else if (ex_we_i && 32'(ex_idx_i) == g)      regs_q[g] <= ex_val_i;
      else if (pre_we_i && 32'(pre_idx_i) == g)    regs_q[g] <= pre_val_i;
    end
  end

  assign ex_rd_o  = (32'(ex_idx_i) < NUM_REGS) ? regs_q[ex_idx_i] : '0;
  assign rd_val_o = (32'(rd_idx_i) < NUM_REGS) ? regs_q[rd_idx_i] : '0;

  // Execution may only move a register by one (R1 increment, R2 decrement)
  AST_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_we_i |-> (ex_val_i == REG_W'(ex_rd_o + 1'b1) || ex_val_i == REG_W'(ex_rd_o - 1'b1))); // R2

  AST_SINGLE_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pre_we_i && ex_we_i)); // R9
endmodule

// File: rtl/cms_ctrl.sv
module cms_ctrl
  import cms_pkg::*;
#(
  parameter int REG_W          = 8,
  parameter int RW             = 2,
  parameter int AW             = 4,
  parameter int IW             = 12,
  parameter bit NEXT_ADDR_MODE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IW-1:0]    word_i,
  input  logic             in_range_i,
  input  logic [REG_W-1:0] opnd_i,
  output logic [AW:0]      pc_o,
  output logic             running_o,
  output logic             halted_o,
  output logic             ex_we_o,
  output logic [RW-1:0]    idx_o,
  output logic [REG_W-1:0] ex_val_o,
  output logic             ovf_o,
  output logic             unf_o
);
  localparam int PCW = AW + 1;

  st_e            st_q;
  logic [PCW-1:0] pc_q;
  logic           ovf_q, unf_q;

  op_e            op;
  logic [AW-1:0]  za, zb;
  logic           is_zero, is_max;
  logic [PCW-1:0] pc_inc, next_pc;
  logic           stop, set_ovf, set_unf, step_we;
  logic [REG_W-1:0] step_val;

  assign op      = op_e'(word_i[IW-1 -: OP_W]);
  assign idx_o   = word_i[IW-OP_W-1 -: RW];
  assign za      = word_i[2*AW-1 -: AW];
  assign zb      = word_i[AW-1:0];
  assign is_zero = (opnd_i == '0);
  assign is_max  = &opnd_i;
  assign pc_inc  = pc_q + 1'b1;

  always_comb begin
    next_pc  = pc_inc;
    step_we  = 1'b0;
    step_val = opnd_i;
    set_ovf  = 1'b0;
    set_unf  = 1'b0;
    stop     = 1'b0;
    if (!in_range_i) begin
      stop = 1'b1;
    end else begin
      unique case (op)
        OP_INC: begin
          if (is_max) set_ovf = 1'b1;
          else begin
            step_we  = 1'b1;
            step_val = opnd_i + 1'b1;
          end
          if (NEXT_ADDR_MODE) next_pc = {1'b0, za};
        end
        OP_DEC: begin
          if (NEXT_ADDR_MODE) begin
            if (is_zero) next_pc = {1'b0, za};
            else begin
              step_we  = 1'b1;
              step_val = opnd_i - 1'b1;
              next_pc  = {1'b0, zb};
            end
          end else if (is_zero) begin
            set_unf = 1'b1;
          end else begin
            step_we  = 1'b1;
            step_val = opnd_i - 1'b1;
          end
        end
        OP_JZ:   if (is_zero) next_pc = {1'b0, za};
        default: stop = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      pc_q  <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (stop) st_q <= ST_DONE;
          else begin
            pc_q  <= next_pc;
            ovf_q <= ovf_q | set_ovf;
            unf_q <= unf_q | set_unf;
          end
        end
        default: begin
          if (start_i) begin
            st_q  <= ST_RUN;
            pc_q  <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
          end
        end
      endcase
    end
  end

  assign running_o = (st_q == ST_RUN);
  assign halted_o  = (st_q == ST_DONE);
  assign ex_we_o   = running_o && step_we;
  assign ex_val_o  = step_val;
  assign pc_o      = pc_q;
  assign ovf_o     = ovf_q;
  assign unf_o     = unf_q;

  AST_HALT_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DONE && !start_i) |=> (st_q == ST_DONE && pc_q == $past(pc_q))); // R4

  AST_OOR_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !in_range_i) |=> (st_q == ST_DONE)); // R5

  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && unf_q) |=> unf_q); // R6

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_RUN && start_i) |=> (!ovf_q && !unf_q && pc_q == '0 && st_q == ST_RUN)); // R8
endmodule

// File: rtl/cm_sequencer.sv
module cm_sequencer #(
  parameter int NUM_REGS       = 4,
  parameter int REG_W          = 8,
  parameter int PROG_DEPTH     = 16,
  parameter bit NEXT_ADDR_MODE = 1'b0,
  parameter logic [PROG_DEPTH*(2+$clog2(NUM_REGS)+2*$clog2(PROG_DEPTH))-1:0] INIT_IMAGE = '1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              start_i,
  input  logic                              prog_we_i,
  input  logic [$clog2(PROG_DEPTH)-1:0]     prog_addr_i,
  input  logic [2+$clog2(NUM_REGS)+2*$clog2(PROG_DEPTH)-1:0] prog_data_i,
  input  logic                              pre_we_i,
  input  logic [$clog2(NUM_REGS)-1:0]       pre_idx_i,
  input  logic [REG_W-1:0]                  pre_val_i,
  input  logic [$clog2(NUM_REGS)-1:0]       rd_idx_i,
  output logic [REG_W-1:0]                  rd_val_o,
  output logic [$clog2(PROG_DEPTH):0]       pc_o,
  output logic                              halted_o,
  output logic                              ovf_o,
  output logic                              unf_o
);
  localparam int RW = $clog2(NUM_REGS);
  localparam int AW = $clog2(PROG_DEPTH);
  localparam int IW = 2 + RW + 2 * AW;

  logic [IW-1:0]    word;
  logic             in_range, running, ex_we;
  logic [RW-1:0]    ex_idx;
  logic [REG_W-1:0] ex_val, opnd;
  logic [AW:0]      pc;

  cms_prog_store #(
    .DEPTH(PROG_DEPTH), .AW(AW), .IW(IW), .INIT_IMAGE(INIT_IMAGE)
  ) i_store (
    .clk_i, .rst_ni,
    .we_i        (prog_we_i && !running),
    .waddr_i     (prog_addr_i),
    .wdata_i     (prog_data_i),
    .fetch_addr_i(pc),
    .word_o      (word),
    .in_range_o  (in_range)
  );

  cms_regfile #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .RW(RW)
  ) i_regs (
    .clk_i, .rst_ni,
    .pre_we_i (pre_we_i && !running),
    .pre_idx_i,
    .pre_val_i,
    .ex_we_i  (ex_we),
    .ex_idx_i (ex_idx),
    .ex_val_i (ex_val),
    .ex_rd_o  (opnd),
    .rd_idx_i,
    .rd_val_o
  );

  cms_ctrl #(
    .REG_W(REG_W), .RW(RW), .AW(AW), .IW(IW), .NEXT_ADDR_MODE(NEXT_ADDR_MODE)
  ) i_ctrl (
    .clk_i, .rst_ni, .start_i,
    .word_i     (word),
    .in_range_i (in_range),
    .opnd_i     (opnd),
    .pc_o       (pc),
    .running_o  (running),
    .halted_o,
    .ex_we_o    (ex_we),
    .idx_o      (ex_idx),
    .ex_val_o   (ex_val),
    .ovf_o,
    .unf_o
  );

  assign pc_o = pc;
endmodule

// File: tb/test_cm_sequencer.sv
module test_cm_sequencer;
  localparam int RW = 2, AW = 4, IW = 12, RWID = 8;
  localparam int K_REG = 0, K_PC = 1, K_HALT = 2, K_OVF = 3, K_UNF = 4, K_LIT = 5;

  typedef struct {
    string req;
    int    kind;
    int    idx;
    int    exp;
    int    lit;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start0 = 1'b0, start1 = 1'b0;
  logic prog_we = 1'b0, pre_we = 1'b0;
  logic [AW-1:0]   prog_addr = '0;
  logic [IW-1:0]   prog_data = '0;
  logic [RW-1:0]   pre_idx = '0, rd_idx = '0;
  logic [RWID-1:0] pre_val = '0;
  logic [RWID-1:0] rd0, rd1;
  logic [AW:0]     pc0, pc1;
  logic            h0, h1, o0, o1, u0, u1;
  bit              sel = 1'b0, done = 1'b0;
  int              checks = 0, fails = 0;
  item_t           exp_q[$];

  always #5 clk = ~clk;

  cm_sequencer i_cm_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start0),
    .prog_we_i(prog_we), .prog_addr_i(prog_addr), .prog_data_i(prog_data),
    .pre_we_i(pre_we), .pre_idx_i(pre_idx), .pre_val_i(pre_val),
    .rd_idx_i(rd_idx), .rd_val_o(rd0), .pc_o(pc0), .halted_o(h0),
    .ovf_o(o0), .unf_o(u0));

  cm_sequencer #(.NEXT_ADDR_MODE(1'b1)) i_cm_sequencer_alt (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start1),
    .prog_we_i(prog_we), .prog_addr_i(prog_addr), .prog_data_i(prog_data),
    .pre_we_i(pre_we), .pre_idx_i(pre_idx), .pre_val_i(pre_val),
    .rd_idx_i(rd_idx), .rd_val_o(rd1), .pc_o(pc1), .halted_o(h1),
    .ovf_o(o1), .unf_o(u1));

  function automatic logic [IW-1:0] enc(int op, int r, int za, int zb);
    return {op[1:0], r[1:0], za[3:0], zb[3:0]};
  endfunction

  // Monitor: pops expected items and compares against the selected design
  always @(negedge clk) begin
    item_t it;
    int act;
    if (exp_q.size() > 0) begin
      it = exp_q.pop_front();
      rd_idx = it.idx[RW-1:0];
      #1;
      case (it.kind)
        K_REG:   act = sel ? int'(rd1) : int'(rd0);
        K_PC:    act = sel ? int'(pc1) : int'(pc0);
        K_HALT:  act = sel ? int'(h1) : int'(h0);
        K_OVF:   act = sel ? int'(o1) : int'(o0);
        K_UNF:   act = sel ? int'(u1) : int'(u0);
        default: act = it.lit;
      endcase
      checks++;
      if (act != it.exp) begin
        fails++;
        $display("FAIL %s kind=%0d idx=%0d actual=%0d expected=%0d", it.req, it.kind, it.idx, act, it.exp);
      end
    end
  end

  task automatic expect_item(string req, int kind, int idx, int exp, int lit = 0);
    item_t it;
    it.req = req; it.kind = kind; it.idx = idx; it.exp = exp; it.lit = lit;
    exp_q.push_back(it);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    @(posedge clk);
  endtask

  task automatic load(int addr, logic [IW-1:0] w);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = addr[AW-1:0]; prog_data = w;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic preload(int r, int v);
    @(negedge clk);
    pre_we = 1'b1; pre_idx = r[RW-1:0]; pre_val = v[RWID-1:0];
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  // mode: 0 plain, 1 inject start/preload/program write during run, 2 preload with start
  task automatic run(bit alt, int mode, int pidx, int pval, output int n);
    @(negedge clk);
    sel = alt;
    if (alt) start1 = 1'b1; else start0 = 1'b1;
    if (mode == 2) begin pre_we = 1'b1; pre_idx = pidx[RW-1:0]; pre_val = pval[RWID-1:0]; end
    @(posedge clk);
    @(negedge clk);
    start0 = 1'b0; start1 = 1'b0; pre_we = 1'b0;
    if (mode == 1) begin
      start0 = 1'b1; pre_we = 1'b1; pre_idx = pidx[RW-1:0]; pre_val = pval[RWID-1:0];
      prog_we = 1'b1; prog_addr = 4'd9; prog_data = enc(0, 0, 0, 0);
    end
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start0 = 1'b0; pre_we = 1'b0; prog_we = 1'b0;
    end while (!(alt ? h1 : h0) && n < 1000);
  endtask

  task automatic load_copy();
    load(0, enc(2, 2, 5, 0));   // JZ r2 -> 5
    load(1, enc(1, 2, 0, 0));   // DEC r2
    load(2, enc(0, 3, 0, 0));   // INC r3
    load(3, enc(0, 1, 0, 0));   // INC r1
    load(4, enc(2, 0, 0, 0));   // JZ r0 -> 0
    load(5, enc(2, 1, 9, 0));   // JZ r1 -> 9
    load(6, enc(1, 1, 0, 0));   // DEC r1
    load(7, enc(0, 2, 0, 0));   // INC r2
    load(8, enc(2, 0, 5, 0));   // JZ r0 -> 5
    load(9, enc(3, 0, 0, 0));   // HALT
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11 reset state
    for (int r = 0; r < 4; r++) expect_item("R11 reg", K_REG, r, 0);
    expect_item("R11 pc", K_PC, 0, 0);
    expect_item("R11 halted", K_HALT, 0, 0);
    expect_item("R11 ovf", K_OVF, 0, 0);
    expect_item("R11 unf", K_UNF, 0, 0);
    drain();

    // R1 R2 R3 R4: copy r2 into r3 through r1, n=3 -> 30 clocks
    load_copy();
    preload(2, 3);
    run(1'b0, 0, 0, 0, n);
    expect_item("R8 cycles copy", K_LIT, 0, 30, n);
    expect_item("R1 r3 increments", K_REG, 3, 3);
    expect_item("R2 r1 drained by decrement", K_REG, 1, 0);
    expect_item("R3 r2 restored via branches", K_REG, 2, 3);
    expect_item("R4 pc on stop word", K_PC, 0, 9);
    expect_item("R4 halted", K_HALT, 0, 1);
    drain();
    repeat (5) @(posedge clk);
    expect_item("R4 pc holds", K_PC, 0, 9);
    expect_item("R4 regs frozen", K_REG, 3, 3);
    drain();

    // R6 underflow
    load(0, enc(1, 1, 0, 0));
    load(1, enc(3, 0, 0, 0));
    run(1'b0, 0, 0, 0, n);
    expect_item("R6 cycles", K_LIT, 0, 2, n);
    expect_item("R6 r1 stays zero", K_REG, 1, 0);
    expect_item("R6 unf set", K_UNF, 0, 1);
    expect_item("R6 ovf clear", K_OVF, 0, 0);
    expect_item("R6 pc", K_PC, 0, 1);
    drain();

    // R7 overflow; R8 start clears previous unf
    preload(1, 255);
    load(0, enc(0, 1, 0, 0));
    run(1'b0, 0, 0, 0, n);
    expect_item("R7 r1 saturated", K_REG, 1, 255);
    expect_item("R7 ovf set", K_OVF, 0, 1);
    expect_item("R8 unf cleared by start", K_UNF, 0, 0);
    drain();

    // R8 R9: start, preload and program write during a run are ignored
    load_copy();
    preload(1, 0);
    preload(3, 0);
    run(1'b0, 1, 3, 99, n);
    expect_item("R8 cycles unchanged by mid-run start", K_LIT, 0, 30, n);
    expect_item("R9 mid-run preload ignored", K_REG, 3, 3);
    expect_item("R9 mid-run program write ignored", K_PC, 0, 9);
    expect_item("R9 r0 untouched", K_REG, 0, 0);
    expect_item("R8 ovf cleared by start", K_OVF, 0, 0);
    drain();

    // R9: preload with start is seen; r3 = 3 + 5, 26+21+1 clocks
    run(1'b0, 2, 2, 5, n);
    expect_item("R9 cycles with start-cycle preload", K_LIT, 0, 48, n);
    expect_item("R9 r3 accumulates preload", K_REG, 3, 8);
    expect_item("R9 r2 restored", K_REG, 2, 5);
    drain();

    // R5: no stop word, run off the end of 16 slots
    for (int a = 0; a < 16; a++) load(a, enc(0, 2, 0, 0));
    preload(2, 0);
    run(1'b0, 0, 0, 0, n);
    expect_item("R5 cycles", K_LIT, 0, 17, n);
    expect_item("R5 r2", K_REG, 2, 16);
    expect_item("R5 pc past end", K_PC, 0, 16);
    expect_item("R5 halted", K_HALT, 0, 1);
    drain();

    // R10: next-address mode doubles r1 into r2
    load(0, enc(1, 1, 3, 1));   // JZDEC r1 zt=3 zf=1
    load(1, enc(0, 2, 2, 0));   // INC r2 -> 2
    load(2, enc(0, 2, 0, 0));   // INC r2 -> 0
    load(3, enc(3, 0, 0, 0));
    preload(1, 4);
    preload(2, 0);
    run(1'b1, 0, 0, 0, n);
    expect_item("R10 cycles", K_LIT, 0, 14, n);
    expect_item("R10 r2 doubled", K_REG, 2, 8);
    expect_item("R10 r1 drained", K_REG, 1, 0);
    expect_item("R10 pc", K_PC, 0, 3);
    expect_item("R10 no underflow on zero test", K_UNF, 0, 0);
    drain();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule